// File: doc/BRIEF.md
# Fused AND Execution Unit for an 8-bit Accumulator Core

This unit executes a small group of non-standard opcodes of an 8-bit accumulator CPU. Each one joins a bitwise AND with a second step in a single operation. Three of these second steps affect the accumulator:

- a carry update taken from the sign of the result;
- a logical right shift;
- a right rotate through carry.

A fifth form loads memory ANDed with the stack pointer. It writes that value into the stack pointer, the accumulator and the X register at once.

The surrounding core supplies several values:

- the opcode;
- the current accumulator, X, stack pointer and status byte;
- the operand byte, which has already been read from memory.

The core then pulses the execute strobe. On that clock edge the unit registers the next register values and the next status byte. Opcodes outside the supported group load the current inputs unchanged and raise an unsupported-opcode output. Fetch, address generation, bus timing and decimal mode are handled elsewhere.

The status byte layout is fixed, because neighbouring logic decodes it:

| Flag | Bit |
|------|-----|
| Negative | 7 |
| Overflow | 6 |
| Zero | 1 |
| Carry | 0 |

Top module: `fused_logic_exec`

## Requirements
- R1: After reset the outputs are accumulator 0x00, X 0x00, stack pointer 0xFF, status 0x00, and the unsupported flag is low.
- R2: Opcodes 0x0B and 0x2B load the accumulator with A AND operand, and set carry (bit 0) equal to bit 7 of that result.
- R3: Opcode 0x4B loads the accumulator with (A AND operand) shifted right by one. Bit 7 becomes 0 and carry takes bit 0 of the AND result. For example, A=0xFF with operand 0x5A gives 0x2D.
- R4: Opcode 0x6B loads the accumulator with (A AND operand) rotated right by one, with the incoming carry entering bit 7. The new carry is result bit 6, and overflow (bit 6) is result bit 6 XOR result bit 5.
- R5: Opcode 0xBB computes stack pointer AND operand and writes it to the stack pointer, the accumulator and X in the same cycle.
- R6: Every supported opcode sets negative (bit 7) from bit 7 of the final value and zero (bit 1) when the final value is 0x00. Status bits that the opcode does not define are copied from the status input.
- R7: While the strobe is low, all register and status outputs hold their values, so a 0xBB result stays in all three registers afterwards.
- R8: On a strobe with any other opcode, the outputs load the accumulator, X, stack pointer and status inputs unchanged. The unsupported flag is high for the following cycle only, unless the next strobe is also unsupported.
- R9: For opcodes 0x0B, 0x2B, 0x4B and 0x6B, X and the stack pointer outputs load the X and stack pointer inputs. For every supported opcode the unsupported flag stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_i | input | 1 | Execute strobe, one cycle per instruction |
| opcode_i | input | 8 | Opcode byte |
| acc_i | input | 8 | Current accumulator |
| x_i | input | 8 | Current X register |
| sp_i | input | 8 | Current stack pointer |
| flags_i | input | 8 | Current status byte |
| operand_i | input | 8 | Operand byte already read from memory |
| acc_o | output | 8 | Registered next accumulator |
| x_o | output | 8 | Registered next X |
| sp_o | output | 8 | Registered next stack pointer |
| flags_o | output | 8 | Registered next status byte |
| bad_op_o | output | 1 | Unsupported opcode seen on the last strobe |

## Verification
Several operand patterns are used with each fused opcode:

- An all-ones accumulator is paired with a mixed operand, so the result is the operand alone. A missing AND, which would leave the accumulator as it was, then shows up as a wrong value.
- Single-bit and zero-producing pairs check the zero flag, and the bit that leaves by the shift or rotate.
- The rotate cases are chosen so that result bits 6 and 5 take all relevant combinations with both incoming carry values. This separates the carry rule from the overflow rule.
- The stack-pointer load is tried with distinct starting A, X and SP values, followed by idle cycles with changing inputs. A late overwrite of any of the three registers would then be seen.

// File: rtl/fx_pkg.sv
package fx_pkg;

    typedef enum logic [2:0] {
        K_NONE,
        K_ANDC,
        K_ANDSHR,
        K_ANDROR,
        K_SPLOAD
    } op_kind_t;

    localparam logic [7:0] OPC_ANDC_A = 8'h0B;
    localparam logic [7:0] OPC_ANDC_B = 8'h2B;
    localparam logic [7:0] OPC_SHR    = 8'h4B;
    localparam logic [7:0] OPC_ROR    = 8'h6B;
    localparam logic [7:0] OPC_SPLD   = 8'hBB;

    // status byte bit positions, decoded by neighbouring logic
    localparam int FLAG_N = 7;
    localparam int FLAG_V = 6;
    localparam int FLAG_Z = 1;
    localparam int FLAG_C = 0;

endpackage

// File: rtl/fx_decode.sv
module fx_decode
    import fx_pkg::*;
#(
    parameter bit ALIAS_EN = 1'b1
) (
    input  logic [7:0] opcode_i,
    output op_kind_t   kind_o
);

    logic alias_hit;

    generate
        if (ALIAS_EN) begin : g_alias
            assign alias_hit = (opcode_i == OPC_ANDC_B);
        end else begin : g_no_alias
            assign alias_hit = 1'b0;
        end
    endgenerate

    always_comb begin
        kind_o = K_NONE;
        if (opcode_i == OPC_ANDC_A || alias_hit) begin
            kind_o = K_ANDC;
        end else if (opcode_i == OPC_SHR) begin
            kind_o = K_ANDSHR;
        end else if (opcode_i == OPC_ROR) begin
            kind_o = K_ANDROR;
        end else if (opcode_i == OPC_SPLD) begin
            kind_o = K_SPLOAD;
        end
    end

endmodule

// File: rtl/fx_datapath.sv
module fx_datapath
    import fx_pkg::*;
#(
    parameter int DW = 8
) (
    input  op_kind_t        kind_i,
    input  logic [DW-1:0]   acc_i,
    input  logic [DW-1:0]   sp_i,
    input  logic [DW-1:0]   operand_i,
    input  logic            carry_i,
    output logic [DW-1:0]   res_o,
    output logic            c_new_o,
    output logic            v_new_o,
    output logic            c_upd_o,
    output logic            v_upd_o
);

    localparam int TOP = DW - 1;

    logic [DW-1:0] and_acc;
    logic [DW-1:0] and_sp;

    assign and_acc = acc_i & operand_i;
    assign and_sp  = sp_i & operand_i;

    always_comb begin
        res_o   = acc_i;
        c_new_o = carry_i;
        v_new_o = 1'b0;
        c_upd_o = 1'b0;
        v_upd_o = 1'b0;
        unique case (kind_i)
            K_ANDC: begin
                res_o   = and_acc;
                c_new_o = and_acc[TOP];
                c_upd_o = 1'b1;
            end
            K_ANDSHR: begin
                res_o   = {1'b0, and_acc[TOP:1]};
                c_new_o = and_acc[0];
                c_upd_o = 1'b1;
            end
            K_ANDROR: begin
                res_o   = {carry_i, and_acc[TOP:1]};
                c_new_o = res_o[TOP-1];
                v_new_o = res_o[TOP-1] ^ res_o[TOP-2];
                c_upd_o = 1'b1;
                v_upd_o = 1'b1;
            end
            K_SPLOAD: begin
                res_o = and_sp;
            end
            default: begin
                res_o = acc_i;
            end
        endcase
    end

endmodule

// File: rtl/fx_flags.sv
module fx_flags
    import fx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [7:0]    flags_i,
    input  logic [DW-1:0] res_i,
    input  logic          c_new_i,
    input  logic          v_new_i,
    input  logic          c_upd_i,
    input  logic          v_upd_i,
    output logic [7:0]    flags_o
);

    always_comb begin
        flags_o         = flags_i;
        flags_o[FLAG_N] = res_i[DW-1];
        flags_o[FLAG_Z] = (res_i == '0);
        if (c_upd_i) begin
            flags_o[FLAG_C] = c_new_i;
        end
        if (v_upd_i) begin
            flags_o[FLAG_V] = v_new_i;
        end
    end

endmodule

// File: rtl/fused_logic_exec.sv
module fused_logic_exec
    import fx_pkg::*;
#(
    parameter int              DW       = 8,
    parameter logic [DW-1:0]   SP_RESET = '1,
    parameter bit              ALIAS_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exec_i,
    input  logic [7:0]    opcode_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] x_i,
    input  logic [DW-1:0] sp_i,
    input  logic [7:0]    flags_i,
    input  logic [DW-1:0] operand_i,
    output logic [DW-1:0] acc_o,
    output logic [DW-1:0] x_o,
    output logic [DW-1:0] sp_o,
    output logic [7:0]    flags_o,
    output logic          bad_op_o
);

    typedef struct packed {
        logic [DW-1:0] acc;
        logic [DW-1:0] x;
        logic [DW-1:0] sp;
        logic [7:0]    flags;
        logic          bad;
    } exec_state_t;

    exec_state_t st_d;
    exec_state_t st_q;

    op_kind_t      kind;
    logic [DW-1:0] res;
    logic          c_new;
    logic          v_new;
    logic          c_upd;
    logic          v_upd;
    logic [7:0]    flags_calc;

    fx_decode #(
        .ALIAS_EN (ALIAS_EN)
    ) i_decode (
        .opcode_i (opcode_i),
        .kind_o   (kind)
    );

    fx_datapath #(
        .DW (DW)
    ) i_datapath (
        .kind_i    (kind),
        .acc_i     (acc_i),
        .sp_i      (sp_i),
        .operand_i (operand_i),
        .carry_i   (flags_i[FLAG_C]),
        .res_o     (res),
        .c_new_o   (c_new),
        .v_new_o   (v_new),
        .c_upd_o   (c_upd),
        .v_upd_o   (v_upd)
    );

    fx_flags #(
        .DW (DW)
    ) i_flags (
        .flags_i (flags_i),
        .res_i   (res),
        .c_new_i (c_new),
        .v_new_i (v_new),
        .c_upd_i (c_upd),
        .v_upd_i (v_upd),
        .flags_o (flags_calc)
    );

    always_comb begin
        st_d     = st_q;
        st_d.bad = 1'b0;
        if (exec_i) begin
            if (kind == K_NONE) begin
                st_d.acc   = acc_i;
                st_d.x     = x_i;
                st_d.sp    = sp_i;
                st_d.flags = flags_i;
                st_d.bad   = 1'b1;
            end else if (kind == K_SPLOAD) begin
                st_d.acc   = res;
                st_d.x     = res;
                st_d.sp    = res;
                st_d.flags = flags_calc;
            end else begin
                st_d.acc   = res;
                st_d.x     = x_i;
                st_d.sp    = sp_i;
                st_d.flags = flags_calc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.acc   <= '0;
            st_q.x     <= '0;
            st_q.sp    <= SP_RESET;
            st_q.flags <= 8'h00;
            st_q.bad   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o    = st_q.acc;
    assign x_o      = st_q.x;
    assign sp_o     = st_q.sp;
    assign flags_o  = st_q.flags;
    assign bad_op_o = st_q.bad;

endmodule

// File: rtl/fx_checker.sv
module fx_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          exec_i,
    input logic [7:0]    opcode_i,
    input logic [DW-1:0] acc_i,
    input logic [DW-1:0] x_i,
    input logic [DW-1:0] sp_i,
    input logic [7:0]    flags_i,
    input logic [DW-1:0] acc_o,
    input logic [DW-1:0] x_o,
    input logic [DW-1:0] sp_o,
    input logic [7:0]    flags_o,
    input logic          bad_op_o
);

    logic acc_kind;
    logic known_op;

    assign acc_kind = (opcode_i == 8'h0B) || (opcode_i == 8'h2B) ||
                      (opcode_i == 8'h4B) || (opcode_i == 8'h6B);
    assign known_op = acc_kind || (opcode_i == 8'hBB);

    p_anc_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i && (opcode_i == 8'h0B || opcode_i == 8'h2B) |=> flags_o[0] == acc_o[DW-1]);

    p_shr_top_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i && opcode_i == 8'h4B |=> !acc_o[DW-1]);

    p_rot_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i && opcode_i == 8'h6B |=>
            (flags_o[0] == acc_o[DW-2]) && (flags_o[6] == (acc_o[DW-2] ^ acc_o[DW-3])));

    p_triple_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i && opcode_i == 8'hBB |=> (acc_o == x_o) && (x_o == sp_o));

    p_nz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i && known_op |=>
            (flags_o[1] == (acc_o == '0)) && (flags_o[7] == acc_o[DW-1]));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> $stable(acc_o) && $stable(x_o) && $stable(sp_o) && $stable(flags_o));

    p_bad_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> !bad_op_o);

    p_bad_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i && !known_op |=> bad_op_o && (acc_o == $past(acc_i)) &&
            (x_o == $past(x_i)) && (sp_o == $past(sp_i)) && (flags_o == $past(flags_i)));

    p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i && acc_kind |=> !bad_op_o && (x_o == $past(x_i)) && (sp_o == $past(sp_i)));

endmodule

bind fused_logic_exec fx_checker #(
    .DW (DW)
) i_fx_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .exec_i   (exec_i),
    .opcode_i (opcode_i),
    .acc_i    (acc_i),
    .x_i      (x_i),
    .sp_i     (sp_i),
    .flags_i  (flags_i),
    .acc_o    (acc_o),
    .x_o      (x_o),
    .sp_o     (sp_o),
    .flags_o  (flags_o),
    .bad_op_o (bad_op_o)
);

// File: tb/test_fused_logic_exec.sv
`timescale 1ns/1ps
module test_fused_logic_exec;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec_i = 1'b0;
    logic [7:0] opcode_i = 8'h00;
    logic [7:0] acc_i = 8'h00;
    logic [7:0] x_i = 8'h00;
    logic [7:0] sp_i = 8'h00;
    logic [7:0] flags_i = 8'h00;
    logic [7:0] operand_i = 8'h00;
    logic [7:0] acc_o, x_o, sp_o, flags_o;
    logic       bad_op_o;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    fused_logic_exec i_fused_logic_exec (
        .clk (clk), .rst_n (rst_n), .exec_i (exec_i), .opcode_i (opcode_i),
        .acc_i (acc_i), .x_i (x_i), .sp_i (sp_i), .flags_i (flags_i),
        .operand_i (operand_i), .acc_o (acc_o), .x_o (x_o), .sp_o (sp_o),
        .flags_o (flags_o), .bad_op_o (bad_op_o)
    );

    // {tag, op, a, x, sp, flags, operand, exp_a, exp_x, exp_sp, exp_flags, exp_bad}
    localparam int NV = 14;
    localparam logic [95:0] VEC [NV] = '{
        {8'd2, 8'h0B, 8'hFF, 8'h11, 8'h22, 8'h00, 8'h5A, 8'h5A, 8'h11, 8'h22, 8'h00, 8'h00},
        {8'd2, 8'h0B, 8'hF0, 8'h11, 8'h22, 8'h24, 8'h81, 8'h80, 8'h11, 8'h22, 8'hA5, 8'h00},
        {8'd6, 8'h2B, 8'h0F, 8'h33, 8'h44, 8'hC3, 8'hF0, 8'h00, 8'h33, 8'h44, 8'h42, 8'h00},
        {8'd3, 8'h4B, 8'hFF, 8'h01, 8'h02, 8'h81, 8'h5A, 8'h2D, 8'h01, 8'h02, 8'h00, 8'h00},
        {8'd3, 8'h4B, 8'h03, 8'h01, 8'h02, 8'h40, 8'h01, 8'h00, 8'h01, 8'h02, 8'h43, 8'h00},
        {8'd3, 8'h4B, 8'hFF, 8'h09, 8'h0A, 8'h00, 8'hFF, 8'h7F, 8'h09, 8'h0A, 8'h01, 8'h00},
        {8'd4, 8'h6B, 8'hFF, 8'h01, 8'h02, 8'h01, 8'hFF, 8'hFF, 8'h01, 8'h02, 8'h81, 8'h00},
        {8'd4, 8'h6B, 8'hFF, 8'h01, 8'h02, 8'h40, 8'h5A, 8'h2D, 8'h01, 8'h02, 8'h40, 8'h00},
        {8'd4, 8'h6B, 8'hC0, 8'h01, 8'h02, 8'h00, 8'hFF, 8'h60, 8'h01, 8'h02, 8'h01, 8'h00},
        {8'd4, 8'h6B, 8'h01, 8'h01, 8'h02, 8'h42, 8'h01, 8'h00, 8'h01, 8'h02, 8'h02, 8'h00},
        {8'd4, 8'h6B, 8'h80, 8'h01, 8'h02, 8'h01, 8'h80, 8'hC0, 8'h01, 8'h02, 8'hC1, 8'h00},
        {8'd5, 8'hBB, 8'h33, 8'h5A, 8'hFF, 8'h01, 8'hA0, 8'hA0, 8'hA0, 8'hA0, 8'h81, 8'h00},
        {8'd5, 8'hBB, 8'h77, 8'h66, 8'h0F, 8'h80, 8'hF0, 8'h00, 8'h00, 8'h00, 8'h02, 8'h00},
        {8'd8, 8'hEA, 8'h12, 8'h34, 8'h56, 8'hC3, 8'h00, 8'h12, 8'h34, 8'h56, 8'hC3, 8'h01}
    };

    task automatic chk(input string req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic check_reset_state();
        chk("R1", "acc", acc_o, 8'h00);
        chk("R1", "x", x_o, 8'h00);
        chk("R1", "sp", sp_o, 8'hFF);
        chk("R1", "flags", flags_o, 8'h00);
        chk("R1", "bad", {7'd0, bad_op_o}, 8'h00);
    endtask

    task automatic strobe(input logic [7:0] op, a, x, sp, f, opd);
        @(negedge clk);
        opcode_i = op; acc_i = a; x_i = x; sp_i = sp; flags_i = f; operand_i = opd;
        exec_i = 1'b1;
        @(negedge clk);
        exec_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state();

        // main table; tag holds the requirement number of the entry
        for (int i = 0; i < NV; i++) begin
            string req;
            logic [95:0] v;
            v = VEC[i];
            req = $sformatf("R%0d", v[95:88]);
            strobe(v[87:80], v[79:72], v[71:64], v[63:56], v[55:48], v[47:40]);
            chk(req, "acc", acc_o, v[39:32]);
            chk(req, "x", x_o, v[31:24]);
            chk(req, "sp", sp_o, v[23:16]);
            chk(req, "flags", flags_o, v[15:8]);
            chk(req, "bad", {7'd0, bad_op_o}, v[7:0]);
        end

        // R8: the unsupported flag drops after one cycle
        @(negedge clk);
        chk("R8", "bad pulse end", {7'd0, bad_op_o}, 8'h00);

        // R7: a 0xBB result stays put while inputs wander with the strobe low
        strobe(8'hBB, 8'h01, 8'h02, 8'h3C, 8'h00, 8'hF5);
        chk("R5", "acc", acc_o, 8'h34);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            opcode_i = 8'hBB; acc_i = 8'h99; x_i = 8'h88; sp_i = 8'hFF; operand_i = 8'hFF;
        end
        chk("R7", "acc held", acc_o, 8'h34);
        chk("R7", "x held", x_o, 8'h34);
        chk("R7", "sp held", sp_o, 8'h34);
        chk("R7", "flags held", flags_o, 8'h00);

        // R9: supported opcode right after unsupported clears the flag
        strobe(8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        chk("R8", "bad set", {7'd0, bad_op_o}, 8'h01);
        strobe(8'h2B, 8'hAA, 8'h05, 8'h06, 8'h00, 8'hF0);
        chk("R9", "bad low", {7'd0, bad_op_o}, 8'h00);
        chk("R2", "alias acc", acc_o, 8'hA0);
        chk("R2", "alias flags", flags_o, 8'h81);

        // R1: reset in mid-run restores reset state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule